// File: doc/BRIEF.md
# Exhaustive Block-Matching Motion Search

This block finds where a square block of the current frame best matches inside a larger search window taken from the reference frame. Every displacement (m,n) with both components between −P and +P is tried. For each one, the block adds up the absolute differences over all BLK_N×BLK_N pixel pairs. The block returns the displacement with the lowest total, together with that total.

Two small on-chip memories hold the pixels: one holds the current block and one holds the search window. They are filled through simple write ports before the search. A single-cycle `start` pulse begins a search. `busy` stays high while the search runs. `done` pulses for one cycle when the best vector and its cost are final.

The search handles one pixel pair per clock cycle and walks every candidate in a fixed order. A candidate replaces the stored best only when its cost is strictly lower, so among equal costs the earliest candidate is kept. The optional parameter SAD_PIPE adds one register stage after the absolute-difference logic. It adds one cycle of latency.

Top module: `bm_search`

## Requirements
- R1: After reset, `busy` and `done` are 0, both vector outputs are 0 and `best_sad` is all ones.
- R2: Current-block pixel (i,j) is stored at address i·BLK_N+j. Window pixel at row r, column c is stored at address r·(BLK_N+2P)+c. Candidate (m,n) compares current pixel (i,j) with window pixel (i+m+P, j+n+P).
- R3: The cost of a candidate is the sum over all i,j of |cur(i,j) − win(i+m+P, j+n+P)|, where pixels are unsigned PIX_W-bit values.
- R4: All (2P+1)² candidates are evaluated. The reported vector is one with the minimum cost, and `best_sad` equals that minimum.
- R5: Candidates are visited with m as the outer loop and n as the inner loop, both counting up from −P. On equal cost, the earliest visited candidate is kept.
- R6: At each start, the running best is cleared to vector (0,0) with a cost above any reachable value. As a result, when every candidate costs the same, the result is (−P,−P).
- R7: `done` is high for exactly one cycle. It rises (BLK_N²·(2P+1)² + 1 + SAD_PIPE) rising edges after the edge that samples `start`. `busy` is high from the edge after `start` until `done` rises, and `done` is never high together with `busy`.
- R8: After `done`, the outputs keep their values until the next accepted start. Writes to either pixel memory do not change them.
- R9: A `start` pulse while `busy` is high is ignored. The running search is neither restarted nor delayed.
- R10: The cost accumulator cannot overflow. The largest possible cost, (2^PIX_W − 1)·BLK_N², is reported exactly.
- R11: `mv_m` and `mv_n` are signed two's-complement values within −P..+P.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search (taken only when idle) |
| cur_we | input | 1 | Write enable, current-block memory |
| cur_waddr | input | $clog2(BLK_N²) | Current-block write address |
| cur_wdata | input | PIX_W | Current-block write pixel |
| win_we | input | 1 | Write enable, search-window memory |
| win_waddr | input | $clog2((BLK_N+2P)²) | Window write address |
| win_wdata | input | PIX_W | Window write pixel |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result strobe |
| mv_m | output | $clog2(P+1)+1 | Best row displacement, signed |
| mv_n | output | $clog2(P+1)+1 | Best column displacement, signed |
| best_sad | output | PIX_W+2·$clog2(BLK_N) | Cost of the best candidate |

## Verification
With the default parameters, the result is due exactly 8·8·81+1 = 5185 rising edges after the edge that samples `start`. The bench counts edges from that sampling edge and expects `done` at that count and at no other. The vector and cost are read on the falling edge of that same cycle. They are read again on later falling edges to confirm they hold, and `done` is checked on the next falling edge to confirm it has dropped. During a run, a second `start` is injected at a known edge count. The bench then checks that `done` still arrives at the same edge count.

// File: rtl/bm_pkg.sv
package bm_pkg;

   // position flags travelling with each pixel pair down the pipeline
   typedef struct packed {
      logic first;   // first pixel of a candidate
      logic last;    // last pixel of a candidate
      logic fin;     // last pixel of the last candidate
   } bm_tag_t;

   function automatic int unsigned bm_bits(input int unsigned v);
      return (v <= 1) ? 1 : $clog2(v);
   endfunction

endpackage

// File: rtl/bm_ram.sv
module bm_ram #(
   parameter int DW    = 8,
   parameter int DEPTH = 64,
   parameter int AW    = 6
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("bm_ram: DEPTH must be at least 2");
      end
      if ((1 << AW) < DEPTH) begin : g_bad_aw
         $error("bm_ram: AW too narrow for DEPTH");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
      rdata <= mem[raddr];
   end

endmodule

// File: rtl/bm_scan.sv
module bm_scan
   import bm_pkg::*;
#(
   parameter int BLK_N   = 8,
   parameter int RANGE_P = 4,
   parameter int IW      = 3,
   parameter int OW      = 4,
   parameter int CA_W    = 6,
   parameter int WA_W    = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            go,
   output logic            active,
   output bm_tag_t         tag,
   output logic [OW-1:0]   mo,
   output logic [OW-1:0]   no,
   output logic [CA_W-1:0] cur_raddr,
   output logic [WA_W-1:0] win_raddr
);

   localparam int WIN  = BLK_N + 2 * RANGE_P;
   localparam int OMAX = 2 * RANGE_P;

   logic          active_q;
   logic [IW-1:0] i_q, j_q;
   logic [OW-1:0] mo_q, no_q;
   logic          j_end, i_end, n_end, m_end;

   assign j_end = (j_q == IW'(BLK_N - 1));
   assign i_end = (i_q == IW'(BLK_N - 1));
   assign n_end = (no_q == OW'(OMAX));
   assign m_end = (mo_q == OW'(OMAX));

   // m outer, n, row i, column j innermost
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         i_q      <= '0;
         j_q      <= '0;
         mo_q     <= '0;
         no_q     <= '0;
      end else if (go) begin
         active_q <= 1'b1;
         i_q      <= '0;
         j_q      <= '0;
         mo_q     <= '0;
         no_q     <= '0;
      end else if (active_q) begin
         if (!j_end) begin
            j_q <= j_q + 1'b1;
         end else begin
            j_q <= '0;
            if (!i_end) begin
               i_q <= i_q + 1'b1;
            end else begin
               i_q <= '0;
               if (!n_end) begin
                  no_q <= no_q + 1'b1;
               end else begin
                  no_q <= '0;
                  if (!m_end) begin
                     mo_q <= mo_q + 1'b1;
                  end else begin
                     mo_q     <= '0;
                     active_q <= 1'b0;
                  end
               end
            end
         end
      end
   end

   assign active    = active_q;
   assign mo        = mo_q;
   assign no        = no_q;
   assign tag.first = (i_q == '0) && (j_q == '0);
   assign tag.last  = i_end && j_end;
   assign tag.fin   = i_end && j_end && n_end && m_end;

   assign cur_raddr = CA_W'(int'(i_q) * BLK_N + int'(j_q));
   assign win_raddr = WA_W'((int'(i_q) + int'(mo_q)) * WIN + int'(j_q) + int'(no_q));

   // R4
   ofs_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active_q |-> (mo_q <= OW'(OMAX)) && (no_q <= OW'(OMAX)));

endmodule

// File: rtl/bm_best.sv
module bm_best
   import bm_pkg::*;
#(
   parameter int PIX_W   = 8,
   parameter int SAD_W   = 14,
   parameter int MV_W    = 4,
   parameter int OW      = 4,
   parameter int RANGE_P = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr,
   input  logic                   in_valid,
   input  bm_tag_t                in_tag,
   input  logic [PIX_W-1:0]       in_diff,
   input  logic [OW-1:0]          in_mo,
   input  logic [OW-1:0]          in_no,
   output logic [SAD_W-1:0]       best_sad,
   output logic signed [MV_W-1:0] mv_m,
   output logic signed [MV_W-1:0] mv_n,
   output logic                   done
);

   localparam logic signed [MV_W-1:0] PMAX = MV_W'(RANGE_P);

   logic [SAD_W-1:0]       acc_q, sum, best_q;
   logic signed [MV_W-1:0] mv_m_q, mv_n_q, cand_m, cand_n;
   logic                   done_q;

   assign sum    = (in_tag.first ? '0 : acc_q) + SAD_W'(in_diff);
   assign cand_m = MV_W'(in_mo) - PMAX;
   assign cand_n = MV_W'(in_no) - PMAX;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         best_q <= '1;
         mv_m_q <= '0;
         mv_n_q <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= in_valid && in_tag.fin;
         if (clr) begin
            acc_q  <= '0;
            best_q <= '1;
            mv_m_q <= '0;
            mv_n_q <= '0;
         end else if (in_valid) begin
            acc_q <= sum;
            // strict compare: equal cost keeps the earlier vector
            if (in_tag.last && (sum < best_q)) begin
               best_q <= sum;
               mv_m_q <= cand_m;
               mv_n_q <= cand_n;
            end
         end
      end
   end

   assign best_sad = best_q;
   assign mv_m     = mv_m_q;
   assign mv_n     = mv_n_q;
   assign done     = done_q;

   // R10
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_tag.first) |-> (sum >= acc_q));

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R4
   best_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (best_q <= $past(best_q)));

   // R8
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !in_valid) |=> ($stable(best_q) && $stable(mv_m_q) && $stable(mv_n_q)));

   // R11
   mv_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mv_m_q >= -PMAX) && (mv_m_q <= PMAX) && (mv_n_q >= -PMAX) && (mv_n_q <= PMAX));

endmodule

// File: rtl/bm_search.sv
module bm_search
   import bm_pkg::*;
#(
   parameter int BLK_N    = 8,
   parameter int RANGE_P  = 4,
   parameter int PIX_W    = 8,
   parameter int SAD_PIPE = 0,
   localparam int WIN     = BLK_N + 2 * RANGE_P,
   localparam int CA_W    = bm_bits(BLK_N * BLK_N),
   localparam int WA_W    = bm_bits(WIN * WIN),
   localparam int SAD_W   = PIX_W + 2 * bm_bits(BLK_N),
   localparam int MV_W    = $clog2(RANGE_P + 1) + 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic                   cur_we,
   input  logic [CA_W-1:0]        cur_waddr,
   input  logic [PIX_W-1:0]       cur_wdata,
   input  logic                   win_we,
   input  logic [WA_W-1:0]        win_waddr,
   input  logic [PIX_W-1:0]       win_wdata,
   output logic                   busy,
   output logic                   done,
   output logic signed [MV_W-1:0] mv_m,
   output logic signed [MV_W-1:0] mv_n,
   output logic [SAD_W-1:0]       best_sad
);

   localparam int IW = bm_bits(BLK_N);
   localparam int OW = bm_bits(2 * RANGE_P + 1);

   generate
      if (BLK_N < 2) begin : g_bad_n
         $error("bm_search: BLK_N must be at least 2");
      end
      if (RANGE_P < 1) begin : g_bad_p
         $error("bm_search: RANGE_P must be at least 1");
      end
      if (PIX_W < 1) begin : g_bad_w
         $error("bm_search: PIX_W must be at least 1");
      end
      if ((SAD_PIPE != 0) && (SAD_PIPE != 1)) begin : g_bad_pipe
         $error("bm_search: SAD_PIPE must be 0 or 1");
      end
   endgenerate

   logic            busy_q, go, fin_evt;
   logic            sc_active;
   bm_tag_t         sc_tag;
   logic [OW-1:0]   sc_mo, sc_no;
   logic [CA_W-1:0] cur_raddr;
   logic [WA_W-1:0] win_raddr;
   logic [PIX_W-1:0] cur_px, win_px, diff;

   assign go = start && !busy_q;

   bm_scan #(
      .BLK_N(BLK_N), .RANGE_P(RANGE_P), .IW(IW), .OW(OW),
      .CA_W(CA_W), .WA_W(WA_W)
   ) u_scan (
      .clk(clk), .rst_n(rst_n), .go(go),
      .active(sc_active), .tag(sc_tag), .mo(sc_mo), .no(sc_no),
      .cur_raddr(cur_raddr), .win_raddr(win_raddr)
   );

   bm_ram #(.DW(PIX_W), .DEPTH(BLK_N * BLK_N), .AW(CA_W)) u_cur_ram (
      .clk(clk), .we(cur_we), .waddr(cur_waddr), .wdata(cur_wdata),
      .raddr(cur_raddr), .rdata(cur_px)
   );

   bm_ram #(.DW(PIX_W), .DEPTH(WIN * WIN), .AW(WA_W)) u_win_ram (
      .clk(clk), .we(win_we), .waddr(win_waddr), .wdata(win_wdata),
      .raddr(win_raddr), .rdata(win_px)
   );

   // stage 1: flags aligned with memory read data
   logic          s1_valid;
   bm_tag_t       s1_tag;
   logic [OW-1:0] s1_mo, s1_no;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_tag   <= '0;
         s1_mo    <= '0;
         s1_no    <= '0;
      end else begin
         s1_valid <= sc_active;
         s1_tag   <= sc_tag;
         s1_mo    <= sc_mo;
         s1_no    <= sc_no;
      end
   end

   assign diff = (cur_px > win_px) ? (cur_px - win_px) : (win_px - cur_px);

   // optional register after the absolute difference
   logic             s2_valid;
   bm_tag_t          s2_tag;
   logic [OW-1:0]    s2_mo, s2_no;
   logic [PIX_W-1:0] s2_diff;

   generate
      if (SAD_PIPE == 1) begin : g_pipe
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               s2_valid <= 1'b0;
               s2_tag   <= '0;
               s2_mo    <= '0;
               s2_no    <= '0;
               s2_diff  <= '0;
            end else begin
               s2_valid <= s1_valid;
               s2_tag   <= s1_tag;
               s2_mo    <= s1_mo;
               s2_no    <= s1_no;
               s2_diff  <= diff;
            end
         end
      end else begin : g_direct
         assign s2_valid = s1_valid;
         assign s2_tag   = s1_tag;
         assign s2_mo    = s1_mo;
         assign s2_no    = s1_no;
         assign s2_diff  = diff;
      end
   endgenerate

   assign fin_evt = s2_valid && s2_tag.fin;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
      end else if (go) begin
         busy_q <= 1'b1;
      end else if (fin_evt) begin
         busy_q <= 1'b0;
      end
   end

   bm_best #(
      .PIX_W(PIX_W), .SAD_W(SAD_W), .MV_W(MV_W), .OW(OW), .RANGE_P(RANGE_P)
   ) u_best (
      .clk(clk), .rst_n(rst_n), .clr(go),
      .in_valid(s2_valid), .in_tag(s2_tag), .in_diff(s2_diff),
      .in_mo(s2_mo), .in_no(s2_no),
      .best_sad(best_sad), .mv_m(mv_m), .mv_n(mv_n), .done(done)
   );

   assign busy = busy_q;

   // R7
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy_q);

   // R9
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !fin_evt) |=> busy_q);

   // R7
   go_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> busy_q);

endmodule

// File: tb/bm_search_bench.sv
module bm_search_bench;

   localparam int N     = 8;
   localparam int P     = 4;
   localparam int W     = N + 2 * P;
   localparam int CA_W  = 6;
   localparam int WA_W  = 8;
   localparam int MV_W  = 4;
   localparam int SAD_W = 14;
   localparam int LAT   = N * N * (2 * P + 1) * (2 * P + 1) + 1;

   typedef struct packed {
      int kind;   // 0 random, 1 planted copy, 2 constant frames, 3 periodic tie
      int seed;
      int em;
      int en;
      int esad;   // -1: no fixed expectation
   } tcase_t;

   localparam int NCASE = 8;
   localparam tcase_t CASES [NCASE] = '{
      '{0, 1,     0,  0, -1},
      '{0, 77,    0,  0, -1},
      '{1, 5,    -4, -4,  0},
      '{1, 9,     4,  4,  0},
      '{1, 13,    3, -2,  0},
      '{2, 255,  -4, -4, 16320},
      '{2, 12850,-4, -4,  0},
      '{3, 0,    -4, -3,  0}
   };

   logic clk = 0;
   logic rst_n = 0;
   logic start = 0;
   logic cur_we = 0;
   logic [CA_W-1:0] cur_waddr = '0;
   logic [7:0] cur_wdata = '0;
   logic win_we = 0;
   logic [WA_W-1:0] win_waddr = '0;
   logic [7:0] win_wdata = '0;
   logic busy, done;
   logic signed [MV_W-1:0] mv_m, mv_n;
   logic [SAD_W-1:0] best_sad;

   always #2.5 clk = ~clk;

   bm_search u_bm_search (
      .clk(clk), .rst_n(rst_n), .start(start),
      .cur_we(cur_we), .cur_waddr(cur_waddr), .cur_wdata(cur_wdata),
      .win_we(win_we), .win_waddr(win_waddr), .win_wdata(win_wdata),
      .busy(busy), .done(done), .mv_m(mv_m), .mv_n(mv_n), .best_sad(best_sad)
   );

   int n_chk = 0;
   int n_fail = 0;
   int cur_img [N * N];
   int win_img [W * W];
   bit [31:0] lcg;

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int rnd8();
      lcg = lcg * 32'd1103515245 + 32'd12345;
      return int'(lcg[23:16]);
   endfunction

   function automatic int g_pat(input int a, input int b);
      return 20 + 40 * a + 70 * b;
   endfunction

   task automatic load_mem();
      for (int k = 0; k < N * N; k++) begin
         @(negedge clk);
         cur_we = 1; cur_waddr = CA_W'(k); cur_wdata = 8'(cur_img[k]);
      end
      for (int k = 0; k < W * W; k++) begin
         @(negedge clk);
         cur_we = 0; win_we = 1; win_waddr = WA_W'(k); win_wdata = 8'(win_img[k]);
      end
      @(negedge clk);
      cur_we = 0; win_we = 0;
   endtask

   task automatic fill(input tcase_t c);
      lcg = 32'(c.seed);
      for (int k = 0; k < W * W; k++) begin
         case (c.kind)
            2: win_img[k] = (c.seed >> 8) & 255;
            3: win_img[k] = g_pat((k / W) % 2, (k % W) % 3);
            default: win_img[k] = rnd8();
         endcase
      end
      for (int i = 0; i < N; i++) begin
         for (int j = 0; j < N; j++) begin
            case (c.kind)
               1: cur_img[i * N + j] = win_img[(i + c.em + P) * W + j + c.en + P];
               2: cur_img[i * N + j] = c.seed & 255;
               3: cur_img[i * N + j] = g_pat(i % 2, (j + 1) % 3);
               default: cur_img[i * N + j] = rnd8();
            endcase
         end
      end
   endtask

   task automatic ref_search(output int bm, output int bn, output int bs);
      bm = 0; bn = 0; bs = 32'h7fffffff;
      for (int m = -P; m <= P; m++) begin
         for (int n = -P; n <= P; n++) begin
            int s;
            s = 0;
            for (int i = 0; i < N; i++) begin
               for (int j = 0; j < N; j++) begin
                  int d;
                  d = cur_img[i * N + j] - win_img[(i + m + P) * W + j + n + P];
                  s += (d < 0) ? -d : d;
               end
            end
            if (bs > s) begin
               bs = s; bm = m; bn = n;
            end
         end
      end
   endtask

   // lat: rising edges from the start-sampling edge to the cycle done is seen
   task automatic run_search(input int poke, output int lat);
      @(negedge clk);
      start = 1;
      @(posedge clk);
      lat = 0;
      @(negedge clk);
      start = (poke == 0);
      while (!done && lat < LAT + 50) begin
         @(posedge clk);
         lat++;
         @(negedge clk);
         start = (poke == lat);
      end
      start = 0;
   endtask

   task automatic run_and_check(input string name, input int poke);
      int lat, bm, bn, bs;
      ref_search(bm, bn, bs);
      run_search(poke, lat);
      check({name, " R7 done latency"}, lat, LAT);
      check({name, " R4 mv_m vs model"}, int'(mv_m), bm);
      check({name, " R4 mv_n vs model"}, int'(mv_n), bn);
      check({name, " R3 cost vs model"}, int'(best_sad), bs);
      check({name, " R11 mv_m range"}, int'(mv_m >= -4 && mv_m <= 4), 1);
      check({name, " R11 mv_n range"}, int'(mv_n >= -4 && mv_n <= 4), 1);
      check({name, " R7 busy low with done"}, int'(busy), 0);
      @(negedge clk);
      check({name, " R7 done single cycle"}, int'(done), 0);
      check({name, " R8 cost held"}, int'(best_sad), bs);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R7 watchdog: actual no finish expected finish within %0d cycles", 190000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check("R1 busy after reset", int'(busy), 0);
      check("R1 done after reset", int'(done), 0);
      check("R1 mv_m after reset", int'(mv_m), 0);
      check("R1 mv_n after reset", int'(mv_n), 0);
      check("R1 cost after reset", int'(best_sad), (1 << SAD_W) - 1);

      for (int c = 0; c < NCASE; c++) begin
         fill(CASES[c]);
         load_mem();
         run_and_check($sformatf("case%0d", c), -1);
         if (CASES[c].esad >= 0) begin
            // R2 planted copies, R5 periodic tie, R6 uniform cost, R10 maximum cost
            check($sformatf("case%0d R2 R5 R6 expected mv_m", c), int'(mv_m), CASES[c].em);
            check($sformatf("case%0d R2 R5 R6 expected mv_n", c), int'(mv_n), CASES[c].en);
            check($sformatf("case%0d R10 expected cost", c), int'(best_sad), CASES[c].esad);
         end
      end

      begin : hold_test
         int hm, hn, hs;
         hm = int'(mv_m); hn = int'(mv_n); hs = int'(best_sad);
         fill('{0, 4242, 0, 0, -1});
         load_mem();
         repeat (5) @(negedge clk);
         check("R8 mv_m after memory writes", int'(mv_m), hm);
         check("R8 mv_n after memory writes", int'(mv_n), hn);
         check("R8 cost after memory writes", int'(best_sad), hs);
         check("R8 no spurious done", int'(done), 0);
      end

      // R9 second start mid-run must be ignored
      fill('{0, 3, 0, 0, -1});
      load_mem();
      run_and_check("R9 restart ignored", 100);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule